// File: doc/BRIEF.md
# NAND Page Access Sequencer

This block runs the complete command sequence that a raw NAND flash needs to read or program one page, or to read the chip's status byte. A request carries an operation code and a 24-bit page number. The block breaks the operation into phases: command bytes, five address bytes, and per-sub-buffer data transfers. It hands each phase to an external low-level cycle engine and waits for that engine's completion strobe. Pin timing and ECC are left to the engine and to the surrounding logic.

Page reads send the open command, the address, and the read-start confirm, then pull the page in 512-byte sub-buffers. Programs send the serial-input command and the address, push the sub-buffers, confirm, and then read status to decide pass or fail. Spare-area and second-half reads go to the chip as ordinary reads; only the data pointer handed to the buffer logic differs. A separate initialisation request reads status and latches a read-only flag. Each phase is guarded by a cycle-count limit, and a stalled engine ends the request with a timeout pulse.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, busy, done, timeout, prog_fail, wp_flag and eng_start are 0, and data_ptr and status_byte are 0.
- R2: Every page operation (op codes 0 to 3) sends exactly five address phases (eng_kind 1) in this order: 0x00, 0x00, page[7:0], page[15:8], page[23:16].
- R3: A read (op 0) sends command 0x00 (eng_kind 0), the five address phases, and command 0x30. It then sends one read transfer (eng_kind 3) per sub-buffer with eng_sub 0, 1, 2 and so on, and then pulses done.
- R4: A program (op 3) sends command 0x80, the five address phases, one write transfer (eng_kind 2) per sub-buffer in ascending eng_sub order, command 0x10, command 0x70, and one status read (eng_kind 4). prog_fail pulses together with done exactly when bit 0 of the returned status byte is 1.
- R5: The number of sub-buffer transfers is PAGE_BYTES/SUB_BYTES: four for a 2048-byte page, and a single transfer with eng_sub 0 for a 512-byte page.
- R6: A spare read (op 1) and a half-page read (op 2) issue the same phase sequence as op 0. data_ptr is set at acceptance to PAGE_BYTES for op 1, to PAGE_BYTES/2 for op 2, and to 0 for every other accepted op.
- R7: A status request (op 4) sends command 0x70 and one status read, then pulses done with status_byte holding the returned byte.
- R8: An initialisation request (op 5) runs the same phases as op 4 and sets wp_flag to the inverse of status bit 7. wp_flag keeps that value until the next initialisation.
- R9: Each phase produces exactly one single-cycle eng_start pulse, and the next phase starts only after eng_done has been seen. For phases other than command and address, eng_byte is 0; for phases other than sub-buffer transfers, eng_sub is 0.
- R10: If eng_done has not arrived TIMEOUT_CYC cycles after an eng_start cycle, timeout pulses in that cycle, busy falls, done does not pulse, and no further eng_start follows.
- R11: A request is accepted only while busy is 0. A request seen while busy, or one with op code 6 or 7, has no effect on the sequence, on data_ptr or on busy.
- R12: busy is 1 from the cycle after acceptance until the cycle in which done or timeout pulses, and it is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation: 0 read, 1 spare read, 2 half read, 3 program, 4 status, 5 initialise |
| req_page | input | 24 | Page number |
| busy | output | 1 | Request in progress |
| done | output | 1 | Single-cycle completion pulse |
| timeout | output | 1 | Single-cycle timeout pulse |
| prog_fail | output | 1 | Program failure, pulses with done |
| wp_flag | output | 1 | Device reported write protection at initialisation |
| status_byte | output | 8 | Last status byte read |
| data_ptr | output | PTR_W | Buffer start offset for the request's data |
| eng_start | output | 1 | Launches one cycle-engine phase |
| eng_kind | output | 3 | Phase kind: 0 command, 1 address, 2 write data, 3 read data, 4 status read |
| eng_byte | output | 8 | Command or address byte |
| eng_sub | output | SUB_W | Sub-buffer index for data phases |
| eng_done | input | 1 | Engine completion strobe |
| eng_rdata | input | 8 | Status byte returned with eng_done on a status read |

## Verification
On every cycle the assertions check the handshake discipline. eng_start is single-cycle and appears only while busy. busy falls only together with a done or timeout pulse, and those two pulses never coincide. prog_fail appears only with done, data_ptr holds while a request runs, and no phase waits beyond the timeout window. The content of the sequence can only be shown by the bench scenarios: the opcodes, the address byte order, the sub-buffer count and indices, the pointer choice, the status decoding and the exact timeout cycle. The bench sweeps every op code over several page numbers and engine latencies, on both a 2048-byte and a 512-byte configuration.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ       = 3'd0,
    OP_READ_SPARE = 3'd1,
    OP_READ_HALF  = 3'd2,
    OP_PROGRAM    = 3'd3,
    OP_STATUS     = 3'd4,
    OP_INIT       = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    XK_CMD    = 3'd0,
    XK_ADDR   = 3'd1,
    XK_WRITE  = 3'd2,
    XK_READ   = 3'd3,
    XK_STATUS = 3'd4
  } xfer_kind_e;

  typedef enum logic [2:0] {
    PH_OPEN,
    PH_ADDR,
    PH_CONFIRM,
    PH_MOVE,
    PH_STAT_CMD,
    PH_STAT_RD
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT
  } step_e;

  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_READ_GO   = 8'h30;
  localparam logic [7:0] CMD_SERIAL_IN = 8'h80;
  localparam logic [7:0] CMD_PROG_GO   = 8'h10;
  localparam logic [7:0] CMD_STATUS    = 8'h70;

  localparam int ADDR_CYCLES = 5;
  localparam int ROW_BYTES   = 3;

endpackage

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expired = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/nand_phase_plan.sv
module nand_phase_plan
  import nand_seq_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int SUB_W   = 2,
  parameter int IDX_W   = 3
) (
  input  op_e              op,
  input  phase_e           phase,
  input  logic [IDX_W-1:0] idx,
  input  logic [23:0]      page,
  output logic [2:0]       kind,
  output logic [7:0]       byte_out,
  output logic [SUB_W-1:0] sub,
  output phase_e           nxt_phase,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_SUB  = IDX_W'(NUM_SUB - 1);
  localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(ADDR_CYCLES - 1);
  localparam logic [IDX_W-1:0] FIRST_ROW = IDX_W'(ADDR_CYCLES - ROW_BYTES);

  logic [7:0] row_byte [4];
  logic       is_prog;
  logic [1:0] row_sel;

  genvar g;
  generate
    for (g = 0; g < ROW_BYTES; g++) begin : g_row
      assign row_byte[g] = page[8*g +: 8];
    end
  endgenerate
  assign row_byte[3] = 8'h00;

  assign is_prog = (op == OP_PROGRAM);
  assign row_sel = 2'(idx - FIRST_ROW);

  always_comb begin
    kind      = 3'(XK_CMD);
    byte_out  = 8'h00;
    sub       = '0;
    nxt_phase = phase;
    nxt_idx   = '0;
    last      = 1'b0;
    case (phase)
      PH_OPEN: begin
        byte_out  = is_prog ? CMD_SERIAL_IN : CMD_READ;
        nxt_phase = PH_ADDR;
      end
      PH_ADDR: begin
        kind     = 3'(XK_ADDR);
        byte_out = (idx >= FIRST_ROW) ? row_byte[row_sel] : 8'h00;
        if (idx == LAST_ADDR) begin
          nxt_phase = is_prog ? PH_MOVE : PH_CONFIRM;
        end else begin
          nxt_idx = idx + IDX_W'(1);
        end
      end
      PH_CONFIRM: begin
        byte_out  = is_prog ? CMD_PROG_GO : CMD_READ_GO;
        nxt_phase = is_prog ? PH_STAT_CMD : PH_MOVE;
      end
      PH_MOVE: begin
        kind = is_prog ? 3'(XK_WRITE) : 3'(XK_READ);
        sub  = idx[SUB_W-1:0];
        if (idx == LAST_SUB) begin
          nxt_phase = PH_CONFIRM;
          last      = !is_prog;
        end else begin
          nxt_idx = idx + IDX_W'(1);
        end
      end
      PH_STAT_CMD: begin
        byte_out  = CMD_STATUS;
        nxt_phase = PH_STAT_RD;
      end
      PH_STAT_RD: begin
        kind = 3'(XK_STATUS);
        last = 1'b1;
      end
      default: begin
        last = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int SUB_BYTES   = 512,
  parameter int SPARE_BYTES = 64,
  parameter int TIMEOUT_CYC = 1000,
  localparam int NUM_SUB = (PAGE_BYTES > SUB_BYTES) ? (PAGE_BYTES / SUB_BYTES) : 1,
  localparam int SUB_W   = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
  localparam int PTR_W   = $clog2(PAGE_BYTES + SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_page,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             prog_fail,
  output logic             wp_flag,
  output logic [7:0]       status_byte,
  output logic [PTR_W-1:0] data_ptr,
  output logic             eng_start,
  output logic [2:0]       eng_kind,
  output logic [7:0]       eng_byte,
  output logic [SUB_W-1:0] eng_sub,
  input  logic             eng_done,
  input  logic [7:0]       eng_rdata
);
  localparam int IDX_W = (SUB_W > 3) ? SUB_W : 3;

  step_e            step;
  op_e              op_q;
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [23:0]      page_q;

  logic [2:0]       plan_kind;
  logic [7:0]       plan_byte;
  logic [SUB_W-1:0] plan_sub;
  phase_e           plan_nxt_phase;
  logic [IDX_W-1:0] plan_nxt_idx;
  logic             plan_last;
  logic             tmr_expired;

  logic             op_ok;
  op_e              req_op_e;
  logic [PTR_W-1:0] ptr_sel;

  assign req_op_e = op_e'(req_op);
  assign op_ok    = (req_op <= 3'(OP_INIT));

  always_comb begin
    case (req_op_e)
      OP_READ_SPARE: ptr_sel = PTR_W'(PAGE_BYTES);
      OP_READ_HALF:  ptr_sel = PTR_W'(PAGE_BYTES / 2);
      default:       ptr_sel = '0;
    endcase
  end

  nand_phase_plan #(
    .NUM_SUB(NUM_SUB),
    .SUB_W  (SUB_W),
    .IDX_W  (IDX_W)
  ) u_plan (
    .op       (op_q),
    .phase    (phase_q),
    .idx      (idx_q),
    .page     (page_q),
    .kind     (plan_kind),
    .byte_out (plan_byte),
    .sub      (plan_sub),
    .nxt_phase(plan_nxt_phase),
    .nxt_idx  (plan_nxt_idx),
    .last     (plan_last)
  );

  nand_wait_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (step == ST_LAUNCH),
    .run    (step == ST_WAIT),
    .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step        <= ST_IDLE;
      op_q        <= OP_READ;
      phase_q     <= PH_OPEN;
      idx_q       <= '0;
      page_q      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      timeout     <= 1'b0;
      prog_fail   <= 1'b0;
      wp_flag     <= 1'b0;
      status_byte <= 8'h00;
      data_ptr    <= '0;
      eng_start   <= 1'b0;
      eng_kind    <= 3'd0;
      eng_byte    <= 8'h00;
      eng_sub     <= '0;
    end else begin
      eng_start <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      prog_fail <= 1'b0;
      case (step)
        ST_IDLE: begin
          if (req_valid && op_ok) begin
            op_q     <= req_op_e;
            page_q   <= req_page;
            busy     <= 1'b1;
            data_ptr <= ptr_sel;
            phase_q  <= (req_op_e == OP_STATUS || req_op_e == OP_INIT) ? PH_STAT_CMD : PH_OPEN;
            idx_q    <= '0;
            step     <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          eng_start <= 1'b1;
          eng_kind  <= plan_kind;
          eng_byte  <= plan_byte;
          eng_sub   <= plan_sub;
          step      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (eng_done) begin
            if (phase_q == PH_STAT_RD) begin
              status_byte <= eng_rdata;
              if (op_q == OP_INIT) begin
                wp_flag <= ~eng_rdata[7];
              end
            end
            if (plan_last) begin
              done      <= 1'b1;
              busy      <= 1'b0;
              prog_fail <= (op_q == OP_PROGRAM) && eng_rdata[0];
              step      <= ST_IDLE;
            end else begin
              phase_q <= plan_nxt_phase;
              idx_q   <= plan_nxt_idx;
              step    <= ST_LAUNCH;
            end
          end else if (tmr_expired) begin
            timeout <= 1'b1;
            busy    <= 1'b0;
            step    <= ST_IDLE;
          end
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_page_seq_chk.sv
module nand_page_seq_chk #(
  parameter int PTR_W       = 12,
  parameter int TIMEOUT_CYC = 1000
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             timeout,
  input logic             prog_fail,
  input logic             eng_start,
  input logic [PTR_W-1:0] data_ptr
);
  logic [31:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy || eng_start) begin
      wcnt <= '0;
    end else begin
      wcnt <= wcnt + 32'd1;
    end
  end

  p_start_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> busy);

  p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  p_busy_end_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || timeout));

  p_pulse_after_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (done || timeout) |-> ($past(busy) && !busy));

  p_done_timeout_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

  p_fail_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    prog_fail |-> done);

  p_ptr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(data_ptr));

  p_wait_bound_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (wcnt <= 32'(TIMEOUT_CYC + 1)));

endmodule

bind nand_page_seq nand_page_seq_chk #(
  .PTR_W      (PTR_W),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .timeout  (timeout),
  .prog_fail(prog_fail),
  .eng_start(eng_start),
  .data_ptr (data_ptr)
);

// File: tb/tb_nand_engine.sv
module tb_nand_engine (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       start,
  input  logic [2:0] kind,
  input  logic [7:0] byte_i,
  input  logic [1:0] sub_i,
  input  int         delay,
  input  logic       stall,
  input  logic [7:0] stat,
  output logic       done,
  output logic [7:0] rdata
);
  logic [2:0] lk [32];
  logic [7:0] lb [32];
  logic [1:0] ls [32];
  int         n;
  int         cnt;
  logic       pend;
  logic [2:0] kq;

  always @(posedge clk) begin
    done <= 1'b0;
    if (rst || clr) begin
      n     <= 0;
      cnt   <= 0;
      pend  <= 1'b0;
      rdata <= 8'h00;
    end else if (start) begin
      if (n < 32) begin
        lk[n] <= kind;
        lb[n] <= byte_i;
        ls[n] <= sub_i;
      end
      n <= n + 1;
      if (!stall) begin
        if (delay <= 1) begin
          done  <= 1'b1;
          rdata <= (kind == 3'd4) ? stat : 8'h00;
        end else begin
          cnt  <= delay - 1;
          pend <= 1'b1;
          kq   <= kind;
        end
      end
    end else if (pend) begin
      if (cnt == 1) begin
        done  <= 1'b1;
        pend  <= 1'b0;
        rdata <= (kq == 3'd4) ? stat : 8'h00;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end
endmodule

// File: tb/tb_nand_page_seq.sv
module tb_nand_page_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rv_l = 1'b0, rv_s = 1'b0, clr = 1'b0;
  logic [2:0]  r_op = 3'd0;
  logic [23:0] r_page = 24'd0;
  int          m_delay = 1;
  logic        m_stall = 1'b0;
  logic [7:0]  m_stat = 8'h00;
  int          sel = 0;

  logic busy_l, done_l, to_l, fail_l, wp_l, st_l, edone_l;
  logic [7:0] sb_l, eb_l, er_l;
  logic [11:0] ptr_l;
  logic [2:0] ek_l;
  logic [1:0] es_l;

  logic busy_s, done_s, to_s, fail_s, wp_s, st_s, edone_s;
  logic [7:0] sb_s, eb_s, er_s;
  logic [9:0] ptr_s;
  logic [2:0] ek_s;
  logic [0:0] es_s;

  nand_page_seq #(.PAGE_BYTES(2048), .SUB_BYTES(512), .SPARE_BYTES(64), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .req_valid(rv_l), .req_op(r_op), .req_page(r_page),
    .busy(busy_l), .done(done_l), .timeout(to_l), .prog_fail(fail_l), .wp_flag(wp_l),
    .status_byte(sb_l), .data_ptr(ptr_l), .eng_start(st_l), .eng_kind(ek_l),
    .eng_byte(eb_l), .eng_sub(es_l), .eng_done(edone_l), .eng_rdata(er_l));

  nand_page_seq #(.PAGE_BYTES(512), .SUB_BYTES(512), .SPARE_BYTES(16), .TIMEOUT_CYC(TMO)) dut_sp (
    .clk(clk), .rst(rst), .req_valid(rv_s), .req_op(r_op), .req_page(r_page),
    .busy(busy_s), .done(done_s), .timeout(to_s), .prog_fail(fail_s), .wp_flag(wp_s),
    .status_byte(sb_s), .data_ptr(ptr_s), .eng_start(st_s), .eng_kind(ek_s),
    .eng_byte(eb_s), .eng_sub(es_s), .eng_done(edone_s), .eng_rdata(er_s));

  tb_nand_engine eng_l (.clk(clk), .rst(rst), .clr(clr), .start(st_l), .kind(ek_l),
    .byte_i(eb_l), .sub_i(es_l), .delay(m_delay), .stall(m_stall), .stat(m_stat),
    .done(edone_l), .rdata(er_l));

  tb_nand_engine eng_s (.clk(clk), .rst(rst), .clr(clr), .start(st_s), .kind(ek_s),
    .byte_i(eb_s), .sub_i({1'b0, es_s}), .delay(m_delay), .stall(m_stall), .stat(m_stat),
    .done(edone_s), .rdata(er_s));

  wire        w_busy = sel ? busy_s : busy_l;
  wire        w_done = sel ? done_s : done_l;
  wire        w_to   = sel ? to_s   : to_l;
  wire        w_fail = sel ? fail_s : fail_l;
  wire        w_wp   = sel ? wp_s   : wp_l;
  wire [7:0]  w_sb   = sel ? sb_s   : sb_l;
  wire [11:0] w_ptr  = sel ? {2'b00, ptr_s} : ptr_l;
  wire        w_st   = sel ? st_s   : st_l;

  int nchk = 0, nfail = 0, cyc_total = 0;
  logic [2:0] ek [32];
  logic [7:0] eb [32];
  logic [1:0] es [32];
  int en;
  logic exp_wp_l = 1'b0, exp_wp_s = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc_total);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic push(input logic [2:0] k, input logic [7:0] b, input logic [1:0] s);
    ek[en] = k; eb[en] = b; es[en] = s; en++;
  endtask

  task automatic build(input logic [2:0] op, input logic [23:0] pg, input int nsub);
    en = 0;
    if (op <= 3) begin
      push(3'd0, (op == 3) ? 8'h80 : 8'h00, 2'd0);
      push(3'd1, 8'h00, 2'd0);
      push(3'd1, 8'h00, 2'd0);
      push(3'd1, pg[7:0], 2'd0);
      push(3'd1, pg[15:8], 2'd0);
      push(3'd1, pg[23:16], 2'd0);
      if (op == 3) begin
        for (int s = 0; s < nsub; s++) push(3'd2, 8'h00, 2'(s));
        push(3'd0, 8'h10, 2'd0);
        push(3'd0, 8'h70, 2'd0);
        push(3'd4, 8'h00, 2'd0);
      end else begin
        push(3'd0, 8'h30, 2'd0);
        for (int s = 0; s < nsub; s++) push(3'd3, 8'h00, 2'(s));
      end
    end else begin
      push(3'd0, 8'h70, 2'd0);
      push(3'd4, 8'h00, 2'd0);
    end
  endtask

  function automatic logic [12:0] got_entry(input int i);
    if (sel) return {eng_s.lk[i], eng_s.lb[i], eng_s.ls[i]};
    return {eng_l.lk[i], eng_l.lb[i], eng_l.ls[i]};
  endfunction

  function automatic int got_n();
    return sel ? eng_s.n : eng_l.n;
  endfunction

  task automatic cmp_seq(input string req, input int from, input int upto);
    int bad = -1;
    for (int i = from; i < upto; i++)
      if (bad < 0 && got_entry(i) != {ek[i], eb[i], es[i]}) bad = i;
    if (bad < 0) chk(1'b1, req, "sequence", 0, 0);
    else chk(1'b0, req, $sformatf("phase %0d {kind,byte,sub}", bad),
             got_entry(bad), {ek[bad], eb[bad], es[bad]});
  endtask

  task automatic issue(input int which, input logic [2:0] op, input logic [23:0] pg);
    r_op = op; r_page = pg;
    if (which != 0) rv_s = 1'b1; else rv_l = 1'b1;
    @(negedge clk);
    rv_s = 1'b0; rv_l = 1'b0;
  endtask

  task automatic run_op(input int which, input logic [2:0] op, input logic [23:0] pg,
                        input int dly, input logic [7:0] stat, input bit poke_busy);
    int nsub = which ? 1 : 4;
    int pbytes = which ? 512 : 2048;
    int cyc = 0;
    bit busy_bad = 0;
    string rq;
    logic [11:0] exp_ptr;
    sel = which; m_delay = dly; m_stat = stat; m_stall = 1'b0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    issue(which, op, pg);
    chk(w_busy == 1'b1, "R12", "busy after accept", w_busy, 1);
    while (!(w_done || w_to) && cyc < 500) begin
      if (!w_busy) busy_bad = 1;
      if (poke_busy && cyc == 3) begin
        r_op = 3'd4; r_page = ~pg;
        if (which != 0) rv_s = 1'b1; else rv_l = 1'b1;
      end else begin
        rv_s = 1'b0; rv_l = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    rv_s = 1'b0; rv_l = 1'b0;
    chk(!busy_bad && !w_busy, "R12", "busy span", {busy_bad, w_busy}, 0);
    chk(w_done && !w_to, "R9", "done without timeout", {w_done, w_to}, 2'b10);
    build(op, pg, nsub);
    case (op)
      3'd0: rq = poke_busy ? "R11" : "R3";
      3'd3: rq = "R4";
      3'd4: rq = "R7";
      3'd5: rq = "R8";
      default: rq = "R6";
    endcase
    if (which != 0) rq = {rq, "/R5"};
    chk(got_n() == en, rq, "phase count", got_n(), en);
    cmp_seq(rq, 0, en);
    if (op <= 3) cmp_seq("R2", 1, 6);
    exp_ptr = (op == 1) ? 12'(pbytes) : (op == 2) ? 12'(pbytes / 2) : 12'd0;
    chk(w_ptr == exp_ptr, "R6", "data_ptr", w_ptr, exp_ptr);
    chk(w_fail == ((op == 3) && stat[0]), "R4", "prog_fail", w_fail, (op == 3) && stat[0]);
    if (op >= 3) chk(w_sb == stat, "R7", "status_byte", w_sb, stat);
    if (op == 5) begin
      if (which != 0) exp_wp_s = ~stat[7]; else exp_wp_l = ~stat[7];
    end
    chk(w_wp == (which ? exp_wp_s : exp_wp_l), "R8", "wp_flag", w_wp,
        which ? exp_wp_s : exp_wp_l);
  endtask

  initial begin
    logic [23:0] pages [4];
    pages[0] = 24'h000000; pages[1] = 24'hABCDEF; pages[2] = 24'hFFFFFF; pages[3] = 24'h5A3C81;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy_l, done_l, to_l, fail_l, wp_l, st_l} == 6'd0 && ptr_l == 0 && sb_l == 0,
        "R1", "reset outputs", {busy_l, done_l, to_l, fail_l, wp_l, st_l, ptr_l, sb_l}, 0);

    for (int op = 0; op < 6; op++)
      for (int p = 0; p < 4; p++)
        for (int d = 1; d <= 4; d += 3)
          run_op(0, 3'(op), pages[p], d, pages[p][7:0] ^ 8'(d * 8'h41), 1'b0);

    run_op(1, 3'd0, 24'h010203, 2, 8'h00, 1'b0);
    run_op(1, 3'd1, 24'h0A0B0C, 1, 8'h00, 1'b0);
    run_op(1, 3'd2, 24'h0A0B0C, 1, 8'h00, 1'b0);
    run_op(1, 3'd3, 24'h778899, 3, 8'h01, 1'b0);
    run_op(1, 3'd5, 24'h000000, 1, 8'h80, 1'b0);

    run_op(0, 3'd0, 24'h314159, 2, 8'h00, 1'b1);
    sel = 0;
    repeat (4) @(negedge clk);
    chk(!busy_l && eng_l.n == 11, "R11", "request while busy ignored", {busy_l, eng_l.n}, 11);

    for (int bad = 6; bad < 8; bad++) begin
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      issue(0, 3'(bad), 24'h123456);
      repeat (3) @(negedge clk);
      chk(!busy_l && eng_l.n == 0 && ptr_l == 0, "R11", "bad op ignored",
          {busy_l, eng_l.n, ptr_l}, 0);
    end

    run_op(0, 3'd4, 24'h000000, TMO - 1, 8'h5C, 1'b0);

    begin
      int t0 = -1, t = 0;
      bit done_seen = 0;
      sel = 0; m_stall = 1'b0; m_delay = TMO;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      issue(0, 3'd4, 24'h0);
      while (!to_l && t < 200) begin
        if (st_l && t0 < 0) t0 = t;
        if (done_l) done_seen = 1;
        @(negedge clk); t++;
      end
      chk(to_l && (t - t0) == TMO, "R10", "timeout cycle (late done)", t - t0, TMO);
      chk(!done_seen && !busy_l && !done_l, "R10", "no done on timeout", {done_seen, busy_l}, 0);
    end

    begin
      int t0 = -1, t = 0;
      bit done_seen = 0;
      sel = 0; m_stall = 1'b1;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      issue(0, 3'd3, 24'h00BEEF);
      while (!to_l && t < 200) begin
        if (st_l && t0 < 0) t0 = t;
        if (done_l) done_seen = 1;
        @(negedge clk); t++;
      end
      chk(to_l && (t - t0) == TMO, "R10", "timeout cycle (stall)", t - t0, TMO);
      repeat (5) @(negedge clk);
      chk(!done_seen && !busy_l && eng_l.n == 1, "R10", "no start after timeout",
          {done_seen, busy_l, eng_l.n}, 1);
      m_stall = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule